// File: doc/BRIEF.md
# Functional Unit Energy Accumulator

This block gives a run-time energy estimate for a processor that is split into functional units, such as decode logic, integer and floating-point datapaths, and register files. Every clock cycle it receives one activity bit per unit. Each unit has two cycle counters. One counts the cycles in which the unit was busy and the other counts the cycles in which it sat idle. An idle unit therefore still adds energy, through its own idle-power constant.

Software programs two 16-bit fixed-point power constants per unit (busy and idle) and a 16-bit clock-period constant through a valid/address/data configuration port. A start pulse launches a sequential calculation that shares a single multiplier. For each unit it forms (busy power × busy cycles + idle power × idle cycles) × period and adds the result into a grand total. A one-cycle done pulse marks the results as valid.

A freeze input holds every counter so that the readout is a consistent snapshot. A synchronous clear input zeroes all counters. A combinational read port selects any counter, any per-unit energy or the total. The results are coarse fixed-point estimates, meant for comparing design points with each other.

Top module: `fu_energy_meter`

## Requirements
- R1: After reset all counters, all per-unit energies and the total read as zero, and both the busy and the done outputs are low.
- R2: In every cycle in which neither clear nor freeze is high, unit u increments its busy counter when bit u of the activity input is 1 and its idle counter when the bit is 0. The other counter of that unit is left unchanged.
- R3: A counter that has reached 2^CNT_W-1 stays at that value and never wraps to zero.
- R4: A high clear input zeroes every counter at the next clock edge, and it takes priority when freeze is high in the same cycle.
- R5: While freeze is high and clear is low, no counter changes, whatever the activity input does.
- R6: A configuration write at address u (u < N) sets the busy power of unit u, address N+u sets the idle power of unit u, and address 2N sets the period. Writes to any higher address change nothing.
- R7: After a calculation, the energy of unit u equals (busy power × busy count + idle power × idle count) × period, computed at full width with no truncation.
- R8: After a calculation, the total equals the sum of all per-unit energies, on both the total output and the read port.
- R9: A start pulse accepted while idle raises busy at the next edge, and done pulses high for exactly one cycle at the 3N-th edge after the start edge. A start pulse given while busy is ignored.
- R10: Read select values 0..N-1 return the busy counters, N..2N-1 the idle counters, 2N..3N-1 the unit energies and 3N the total. Every other select value returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unit_active_i | input | N_UNITS | One activity bit per unit for this cycle |
| clear_i | input | 1 | Synchronous clear of all counters |
| freeze_i | input | 1 | Holds all counters |
| cfg_valid_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | $clog2(2*N_UNITS+1) | Configuration register address |
| cfg_data_i | input | K_W | Configuration write data |
| calc_start_i | input | 1 | Starts an energy calculation |
| rd_sel_i | input | $clog2(3*N_UNITS+1) | Read port select |
| rd_data_o | output | 2*K_W+CNT_W+1+$clog2(N_UNITS) | Selected counter or energy, zero-extended |
| total_energy_o | output | 2*K_W+CNT_W+1+$clog2(N_UNITS) | Total energy from the last calculation |
| calc_busy_o | output | 1 | Calculation in progress |
| calc_done_o | output | 1 | One-cycle pulse when results are valid |

## Verification
Clear and freeze can both be high in the same cycle, and clear must then win. The bench raises both together on one edge while every unit reports activity. It checks that all counters read zero afterwards and that they stay at zero while freeze alone is held. Counting must then resume from zero once freeze drops. A second overlap is a start pulse that arrives while a calculation is already running. The bench checks that done still falls on the cycle set by the first start and that no second run follows.

// File: rtl/fue_pkg.sv
// Shared types for the functional-unit energy accumulator.
// Assumes: included first in compile order.
package fue_pkg;

    // Calculation engine top-level state
    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

    // Step within one unit's calculation: busy term, idle term, period scaling
    typedef enum logic [1:0] {
        PH_BUSY  = 2'd0,
        PH_REST  = 2'd1,
        PH_SCALE = 2'd2
    } eng_phase_e;

endpackage

// File: rtl/fue_unit_counter.sv
// Busy/idle cycle counter pair for one functional unit.
// Counts exactly one of the two per unfrozen cycle, saturates at all-ones.
// Assumes: clear has priority over freeze; reset is synchronous active-low.
module fue_unit_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             freeze_i,
    input  logic             active_i,
    output logic [CNT_W-1:0] busy_cnt_o,
    output logic [CNT_W-1:0] rest_cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count busy or idle cycle, saturating, with clear over freeze
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            busy_cnt_o <= '0;
            rest_cnt_o <= '0;
        end else if (!freeze_i) begin
            if (active_i) begin
                if (busy_cnt_o != CNT_MAX) busy_cnt_o <= busy_cnt_o + 1'b1;
            end else begin
                if (rest_cnt_o != CNT_MAX) rest_cnt_o <= rest_cnt_o + 1'b1;
            end
        end
    end

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (busy_cnt_o == '0 && rest_cnt_o == '0));

    // R5
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !clear_i) |=> ($stable(busy_cnt_o) && $stable(rest_cnt_o)));

    // R3
    busy_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && busy_cnt_o == CNT_MAX) |=> busy_cnt_o == CNT_MAX);

    // R3
    rest_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && rest_cnt_o == CNT_MAX) |=> rest_cnt_o == CNT_MAX);

    // R2
    busy_side_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !freeze_i && active_i) |=> $stable(rest_cnt_o));

    // R2
    rest_side_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !freeze_i && !active_i) |=> $stable(busy_cnt_o));

endmodule

// File: rtl/fue_cfg_regs.sv
// Power and period constant registers written through a valid/address/data port.
// Map: u -> busy power of unit u, N+u -> idle power of unit u, 2N -> period.
// Assumes: higher addresses are silently ignored; registers reset to zero.
module fue_cfg_regs #(
    parameter int N_UNITS = 8,
    parameter int K_W     = 16,
    parameter int ADDR_W  = $clog2(2*N_UNITS+1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_valid_i,
    input  logic [ADDR_W-1:0]            cfg_addr_i,
    input  logic [K_W-1:0]               cfg_data_i,
    output logic [N_UNITS-1:0][K_W-1:0]  busy_pwr_o,
    output logic [N_UNITS-1:0][K_W-1:0]  rest_pwr_o,
    output logic [K_W-1:0]               period_o
);

    localparam logic [ADDR_W-1:0] PERIOD_ADDR = ADDR_W'(2*N_UNITS);

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit_cfg
        // Hold busy and idle power constants of this unit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_pwr_o[u] <= '0;
                rest_pwr_o[u] <= '0;
            end else if (cfg_valid_i) begin
                if (cfg_addr_i == ADDR_W'(u))           busy_pwr_o[u] <= cfg_data_i;
                if (cfg_addr_i == ADDR_W'(N_UNITS + u)) rest_pwr_o[u] <= cfg_data_i;
            end
        end
    end

    // Hold the clock period constant
    always_ff @(posedge clk) begin
        if (!rst_n) period_o <= '0;
        else if (cfg_valid_i && cfg_addr_i == PERIOD_ADDR) period_o <= cfg_data_i;
    end

    // R6
    period_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_i && cfg_addr_i == PERIOD_ADDR) |=> period_o == $past(cfg_data_i));

    // R6
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_i && cfg_addr_i > PERIOD_ADDR) |=>
            ($stable(period_o) && $stable(busy_pwr_o) && $stable(rest_pwr_o)));

endmodule

// File: rtl/fue_energy_engine.sv
// Sequential energy calculator sharing one multiplier across all units.
// Per unit: acc = Pb*Cb; acc += Pr*Cr; E = acc*T (three cycles), total += E.
// Assumes: counters and constants are held steady (freeze) during a run.
module fue_energy_engine
    import fue_pkg::*;
#(
    parameter int N_UNITS = 8,
    parameter int CNT_W   = 32,
    parameter int K_W     = 16,
    localparam int ACC_W  = K_W + CNT_W + 1,
    localparam int UE_W   = K_W + ACC_W,
    localparam int TOT_W  = UE_W + $clog2(N_UNITS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [N_UNITS-1:0][K_W-1:0]   busy_pwr_i,
    input  logic [N_UNITS-1:0][K_W-1:0]   rest_pwr_i,
    input  logic [K_W-1:0]                period_i,
    input  logic [N_UNITS-1:0][CNT_W-1:0] busy_cnt_i,
    input  logic [N_UNITS-1:0][CNT_W-1:0] rest_cnt_i,
    output logic [N_UNITS-1:0][UE_W-1:0]  unit_energy_o,
    output logic [TOT_W-1:0]              total_o,
    output logic                          busy_o,
    output logic                          done_o
);

    localparam int IDX_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_UNITS - 1);

    eng_state_e        state_q;
    eng_phase_e        phase_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ACC_W-1:0]  acc_q;
    logic [K_W-1:0]    op_a;
    logic [ACC_W-1:0]  op_b;
    logic [UE_W-1:0]   product;

    // Select multiplier operands for the current step
    always_comb begin
        op_a = busy_pwr_i[idx_q];
        op_b = ACC_W'(busy_cnt_i[idx_q]);
        case (phase_q)
            PH_REST: begin
                op_a = rest_pwr_i[idx_q];
                op_b = ACC_W'(rest_cnt_i[idx_q]);
            end
            PH_SCALE: begin
                op_a = period_i;
                op_b = acc_q;
            end
            default: ;
        endcase
    end

    // The single shared multiplier
    assign product = UE_W'(op_a) * UE_W'(op_b);

    // Step through units and phases, accumulate results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ENG_IDLE;
            phase_q       <= PH_BUSY;
            idx_q         <= '0;
            acc_q         <= '0;
            total_o       <= '0;
            unit_energy_o <= '0;
            done_o        <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (state_q == ENG_IDLE) begin
                if (start_i) begin
                    state_q <= ENG_RUN;
                    phase_q <= PH_BUSY;
                    idx_q   <= '0;
                    total_o <= '0;
                end
            end else begin
                case (phase_q)
                    PH_BUSY: begin
                        acc_q   <= ACC_W'(product);
                        phase_q <= PH_REST;
                    end
                    PH_REST: begin
                        acc_q   <= acc_q + ACC_W'(product);
                        phase_q <= PH_SCALE;
                    end
                    default: begin
                        unit_energy_o[idx_q] <= product;
                        total_o              <= total_o + TOT_W'(product);
                        phase_q              <= PH_BUSY;
                        if (idx_q == LAST_IDX) begin
                            state_q <= ENG_IDLE;
                            done_o  <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    assign busy_o = (state_q == ENG_RUN);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R9
    done_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8
    total_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && phase_q == PH_SCALE) |=> total_o >= $past(total_o));

endmodule

// File: rtl/fu_energy_meter.sv
// Top of the functional-unit energy accumulator: per-unit busy/idle counters,
// constant registers, shared-multiplier energy engine and a read multiplexer.
// Assumes: software freezes the counters before starting a calculation.
module fu_energy_meter #(
    parameter int N_UNITS = 8,
    parameter int CNT_W   = 32,
    parameter int K_W     = 16,
    localparam int ADDR_W = $clog2(2*N_UNITS+1),
    localparam int SEL_W  = $clog2(3*N_UNITS+1),
    localparam int RD_W   = 2*K_W + CNT_W + 1 + $clog2(N_UNITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_UNITS-1:0] unit_active_i,
    input  logic               clear_i,
    input  logic               freeze_i,
    input  logic               cfg_valid_i,
    input  logic [ADDR_W-1:0]  cfg_addr_i,
    input  logic [K_W-1:0]     cfg_data_i,
    input  logic               calc_start_i,
    input  logic [SEL_W-1:0]   rd_sel_i,
    output logic [RD_W-1:0]    rd_data_o,
    output logic [RD_W-1:0]    total_energy_o,
    output logic               calc_busy_o,
    output logic               calc_done_o
);

    localparam int UE_W = 2*K_W + CNT_W + 1;

    logic [N_UNITS-1:0][CNT_W-1:0] busy_cnt;
    logic [N_UNITS-1:0][CNT_W-1:0] rest_cnt;
    logic [N_UNITS-1:0][K_W-1:0]   busy_pwr;
    logic [N_UNITS-1:0][K_W-1:0]   rest_pwr;
    logic [K_W-1:0]                period;
    logic [N_UNITS-1:0][UE_W-1:0]  unit_energy;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_cnt
        fue_unit_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear_i    (clear_i),
            .freeze_i   (freeze_i),
            .active_i   (unit_active_i[u]),
            .busy_cnt_o (busy_cnt[u]),
            .rest_cnt_o (rest_cnt[u])
        );
    end

    fue_cfg_regs #(.N_UNITS(N_UNITS), .K_W(K_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_valid_i (cfg_valid_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_data_i  (cfg_data_i),
        .busy_pwr_o  (busy_pwr),
        .rest_pwr_o  (rest_pwr),
        .period_o    (period)
    );

    fue_energy_engine #(.N_UNITS(N_UNITS), .CNT_W(CNT_W), .K_W(K_W)) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (calc_start_i),
        .busy_pwr_i    (busy_pwr),
        .rest_pwr_i    (rest_pwr),
        .period_i      (period),
        .busy_cnt_i    (busy_cnt),
        .rest_cnt_i    (rest_cnt),
        .unit_energy_o (unit_energy),
        .total_o       (total_energy_o),
        .busy_o        (calc_busy_o),
        .done_o        (calc_done_o)
    );

    // Read multiplexer over counters, unit energies and total
    always_comb begin
        rd_data_o = '0;
        for (int u = 0; u < N_UNITS; u++) begin
            if (rd_sel_i == SEL_W'(u))             rd_data_o = RD_W'(busy_cnt[u]);
            if (rd_sel_i == SEL_W'(N_UNITS + u))   rd_data_o = RD_W'(rest_cnt[u]);
            if (rd_sel_i == SEL_W'(2*N_UNITS + u)) rd_data_o = RD_W'(unit_energy[u]);
        end
        if (rd_sel_i == SEL_W'(3*N_UNITS)) rd_data_o = total_energy_o;
    end

endmodule

// File: tb/sim_fu_energy_meter.sv
`timescale 1ns/10ps
// Directed bench for the functional-unit energy accumulator.
module sim_fu_energy_meter;

    localparam int NU   = 4;
    localparam int CW   = 6;
    localparam int KW   = 16;
    localparam int AW   = $clog2(2*NU+1);
    localparam int SW   = $clog2(3*NU+1);
    localparam int RW   = 2*KW + CW + 1 + $clog2(NU);
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NU-1:0] act = '0;
    logic          clear = 1'b0;
    logic          freeze = 1'b0;
    logic          cfg_v = 1'b0;
    logic [AW-1:0] cfg_a = '0;
    logic [KW-1:0] cfg_d = '0;
    logic          start = 1'b0;
    logic [SW-1:0] sel = '0;
    logic [RW-1:0] rd;
    logic [RW-1:0] tot;
    logic          busy;
    logic          done;

    int     errors = 0;
    int     checks = 0;
    int     m_busy [NU];
    int     m_rest [NU];
    longint pb [NU];
    longint pr [NU];
    longint per = 0;

    always #2.5 clk = ~clk;

    fu_energy_meter #(.N_UNITS(NU), .CNT_W(CW), .K_W(KW)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .unit_active_i  (act),
        .clear_i        (clear),
        .freeze_i       (freeze),
        .cfg_valid_i    (cfg_v),
        .cfg_addr_i     (cfg_a),
        .cfg_data_i     (cfg_d),
        .calc_start_i   (start),
        .rd_sel_i       (sel),
        .rd_data_o      (rd),
        .total_energy_o (tot),
        .calc_busy_o    (busy),
        .calc_done_o    (done)
    );

    // Expected counter values, derived from R2 R3 R4 R5
    always @(posedge clk) begin
        for (int u = 0; u < NU; u++) begin
            if (!rst_n || clear) begin
                m_busy[u] <= 0;
                m_rest[u] <= 0;
            end else if (!freeze) begin
                if (act[u]) begin
                    if (m_busy[u] < CMAX) m_busy[u] <= m_busy[u] + 1;
                end else if (m_rest[u] < CMAX) begin
                    m_rest[u] <= m_rest[u] + 1;
                end
            end
        end
    end

    task automatic check(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic read_sel(input int s, output longint v);
        sel = SW'(s);
        #0.05;
        v = longint'(rd);
    endtask

    function automatic longint exp_energy(input int u);
        return (pb[u] * m_busy[u] + pr[u] * m_rest[u]) * per;
    endfunction

    task automatic cfg_write(input int a, input int d);
        cfg_v = 1'b1;
        cfg_a = AW'(a);
        cfg_d = KW'(d);
        @(negedge clk);
        cfg_v = 1'b0;
        if (a < NU) pb[a] = d;
        else if (a < 2*NU) pr[a-NU] = d;
        else if (a == 2*NU) per = d;
    endtask

    task automatic run(input logic [NU-1:0] pat, input int n);
        act = pat;
        repeat (n) @(negedge clk);
    endtask

    task automatic check_counts(input string tag);
        longint v;
        for (int u = 0; u < NU; u++) begin
            read_sel(u, v);      check({tag, " busy count"}, v, m_busy[u]);
            read_sel(NU + u, v); check({tag, " idle count"}, v, m_rest[u]);
        end
    endtask

    // R1 R10: everything reads zero after reset, unmapped selects read zero
    task automatic t_reset();
        longint v;
        for (int s = 0; s < 16; s++) begin
            read_sel(s, v);
            check("R1/R10 reset readout", v, 0);
        end
        check("R1 done low", done, 0);
        check("R1 busy low", busy, 0);
        check("R1 total low", longint'(tot), 0);
    endtask

    task automatic t_configure();
        cfg_write(0, 1200); cfg_write(1, 300); cfg_write(2, 65535); cfg_write(3, 7);
        cfg_write(4, 40);   cfg_write(5, 0);   cfg_write(6, 65535); cfg_write(7, 3);
        cfg_write(8, 250);
    endtask

    // R2: mixed activity patterns
    task automatic t_count();
        run(4'b0101, 10);
        run(4'b0011, 7);
        run(4'b1000, 3);
        check_counts("R2");
    endtask

    // R5: freeze holds counters while all units are active
    task automatic t_freeze();
        freeze = 1'b1;
        run(4'b1111, 5);
        check_counts("R5 freeze");
    endtask

    // R7 R8 R9: calculation timing and results (freeze must be high)
    task automatic t_energy(input string tag, input bit retrig);
        longint v;
        longint sum = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 busy after start", busy, 1);
        for (int c = 1; c <= 3*NU + 1; c++) begin
            @(negedge clk);
            check("R9 done timing", done, (c == 3*NU) ? 1 : 0);
            if (retrig && c == 2) start = 1'b1;
            if (retrig && c == 3) start = 1'b0;
        end
        check("R9 idle after done", busy, 0);
        for (int u = 0; u < NU; u++) begin
            read_sel(2*NU + u, v);
            check({tag, " R7 unit energy"}, v, exp_energy(u));
            sum += exp_energy(u);
        end
        read_sel(3*NU, v);
        check({tag, " R8 total via read"}, v, sum);
        check({tag, " R8 total output"}, longint'(tot), sum);
    endtask

    // R3: busy counter of unit 0 saturates
    task automatic t_saturate();
        longint v;
        freeze = 1'b0;
        run(4'b0001, 70);
        read_sel(0, v);
        check("R3 saturated busy count", v, 63);
        check_counts("R3");
    endtask

    // R4 R5: clear and freeze together, clear wins
    task automatic t_clear_freeze();
        clear  = 1'b1;
        freeze = 1'b1;
        act    = 4'b1111;
        @(negedge clk);
        clear = 1'b0;
        check_counts("R4 clear with freeze");
        for (int u = 0; u < NU; u++) check("R4 zero model", m_busy[u] + m_rest[u], 0);
        run(4'b1111, 4);
        check_counts("R5 held at zero");
        freeze = 1'b0;
        run(4'b0110, 5);
        check_counts("R2 resume");
    endtask

    // R6: writes above the period address change nothing
    task automatic t_ignored_cfg();
        for (int a = 2*NU + 1; a < (1 << AW); a++) cfg_write(a, 16'hFFFF);
        freeze = 1'b1;
        t_energy("R6 unmapped writes", 1'b0);
    endtask

    initial begin
        for (int u = 0; u < NU; u++) begin
            pb[u] = 0;
            pr[u] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_configure();
        t_count();
        t_freeze();
        t_energy("first run", 1'b1);
        t_saturate();
        freeze = 1'b1;
        t_energy("saturated run", 1'b0);
        t_clear_freeze();
        t_ignored_cfg();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule